// File: doc/BRIEF.md
# Indexed Register Access Sequencer

This block lets on-chip logic reach a peripheral whose registers sit behind an indirect address/data pair. A caller presents a register index, a direction flag and, for writes, a 32-bit value. The sequencer first places the index on a shared 16-bit bus with the address strobe active. It then moves one or two 16-bit words with the data strobe active, and it hands the result back with a single-cycle completion pulse.

The peripheral needs time to settle after each phase. The sequencer counts clock cycles for two minimum quiet periods: a longer one after the index phase, and a shorter one after every data word. Both lengths come from nanosecond parameters and the clock period, rounded up to whole cycles. Registers whose index byte is below 0x20 are 32 bits wide and take two data words. The others are 16 bits wide and take one.

Top module: `ixbus_bridge`

## Requirements
- R1: Each access begins with one address-phase strobe, with write enable asserted and the bus carrying the low 8 bits of the request index. Bit 7 is forced to 1 for a write and left as given for a read. Bits above 7 are never sent.
- R2: An index whose low byte is below 0x20 moves 32 bits as two data words, bits 15:0 first and bits 31:16 second. A read places the second word in rsp_rdata[31:16].
- R3: An index whose low byte is 0x20 or above takes exactly one data word. A write sends req_wdata[15:0], and a read returns the word zero-extended to 32 bits.
- R4: At least ceil(ADDR_SETTLE_NS / CLK_PERIOD_NS) clock cycles (30 by default) with no strobe active separate the end of the address strobe from the first data strobe.
- R5: At least ceil(DATA_SETTLE_NS / CLK_PERIOD_NS) quiet cycles (15 by default) follow every data strobe before the next data strobe or the next address strobe.
- R6: Address strobe, data strobe, read enable and write enable all stay deasserted and unchanged throughout each enforced quiet period.
- R7: The sequencer drives bus_data only while bus_wren is high. During a read strobe it leaves the bus released and captures the word on the last cycle of that strobe.
- R8: A request is accepted only while req_ready is high, which happens only when the sequencer is idle. req_ready stays low from acceptance until the final quiet period has expired, and a request presented while busy causes no bus activity.
- R9: rsp_done is high for exactly one cycle per access, and rsp_rdata holds the read result in that cycle.
- R10: While rst_n is low, all four strobes are deasserted, rsp_done is low, req_ready is high and bus_data is released, including when reset arrives in the middle of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_index | input | REQ_IDX_W | Register index (low 8 bits used) |
| req_wdata | input | 32 | Write value |
| rsp_rdata | output | 32 | Read result |
| rsp_done | output | 1 | One-cycle completion pulse |
| bus_astb | output | 1 | Address-phase strobe |
| bus_dstb | output | 1 | Data-phase strobe |
| bus_rden | output | 1 | Read enable |
| bus_wren | output | 1 | Write enable |
| bus_data | inout | 16 | Shared index/data bus |

## Verification
A wrong phase state or a mis-loaded cycle counter shows on the strobe pins within the same access. Such faults appear as a quiet period shorter than its bound, a missing or extra data strobe, or write enable present during a read. A wrong width decision or word-select bit shows as a missing or misplaced half-word in rsp_rdata, or as a half-word stored in the wrong place in the bench's register model, at the next rsp_done pulse. A sequencer stuck outside idle shows as req_ready never returning, and the bench catches this within a bounded wait.

// File: rtl/ixb_pkg.sv
package ixb_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_AGAP = 3'd2,
    PH_DATA = 3'd3,
    PH_DGAP = 3'd4
  } phase_t;

  localparam int WORD_W     = 16;
  localparam int REG_W      = 32;
  localparam int PORT_IDX_W = 8;
  localparam logic [PORT_IDX_W-1:0] WRITE_FLAG = 8'h80;

  // Nanoseconds to whole cycles, rounded up, never below one cycle.
  function automatic int ns_to_cycles(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/ixb_gap_timer.sv
module ixb_gap_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // R4 R5: a running count falls by exactly one per cycle.
  assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ixb_ctrl.sv
module ixb_ctrl
  import ixb_pkg::*;
#(
  parameter int STB_CYC    = 2,
  parameter int AGAP_CYC   = 30,
  parameter int DGAP_CYC   = 15,
  parameter int CNT_W      = 5,
  parameter int WIDE_BELOW = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [PORT_IDX_W-1:0] req_port_idx,
  input  logic                  expired,
  output logic                  load,
  output logic [CNT_W-1:0]      load_val,
  output phase_t                phase,
  output logic                  word_sel,
  output logic                  capture,
  output logic                  sample,
  output logic                  done,
  output logic                  astb,
  output logic                  dstb,
  output logic                  rden,
  output logic                  wren
);

  localparam logic [CNT_W-1:0] STB_LD  = CNT_W'(STB_CYC - 1);
  localparam logic [CNT_W-1:0] AGAP_LD = CNT_W'(AGAP_CYC - 1);
  localparam logic [CNT_W-1:0] DGAP_LD = CNT_W'(DGAP_CYC - 1);

  phase_t state_q, state_d;
  logic   word_q, word_d;
  logic   wr_q, wide_q;
  logic   done_q, done_d;

  assign capture = (state_q == PH_IDLE) && req_valid;

  always_comb begin
    state_d  = state_q;
    word_d   = word_q;
    load     = 1'b0;
    load_val = '0;
    done_d   = 1'b0;
    unique case (state_q)
      PH_IDLE: if (req_valid) begin
        state_d  = PH_ADDR;
        word_d   = 1'b0;
        load     = 1'b1;
        load_val = STB_LD;
      end
      PH_ADDR: if (expired) begin
        state_d  = PH_AGAP;
        load     = 1'b1;
        load_val = AGAP_LD;
      end
      PH_AGAP: if (expired) begin
        state_d  = PH_DATA;
        load     = 1'b1;
        load_val = STB_LD;
      end
      PH_DATA: if (expired) begin
        state_d  = PH_DGAP;
        load     = 1'b1;
        load_val = DGAP_LD;
        done_d   = !wide_q || word_q;
      end
      PH_DGAP: if (expired) begin
        if (wide_q && !word_q) begin
          state_d  = PH_DATA;
          word_d   = 1'b1;
          load     = 1'b1;
          load_val = STB_LD;
        end else begin
          state_d  = PH_IDLE;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      word_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      word_q  <= word_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      wide_q <= 1'b0;
    end else if (capture) begin
      wr_q   <= req_write;
      wide_q <= (int'(req_port_idx) < WIDE_BELOW);
    end
  end

  assign phase    = state_q;
  assign word_sel = word_q;
  assign done     = done_q;
  assign astb     = (state_q == PH_ADDR);
  assign dstb     = (state_q == PH_DATA);
  assign wren     = astb || (dstb && wr_q);
  assign rden     = dstb && !wr_q;
  assign sample   = rden && expired;

  // Checker state: saturating count of strobe-free cycles.
  localparam int RUN_W = CNT_W + 1;
  logic [RUN_W-1:0] quiet_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   quiet_run_q <= '1;
    else if (astb || dstb)        quiet_run_q <= '0;
    else if (quiet_run_q != '1)   quiet_run_q <= quiet_run_q + 1'b1;
  end

  assert_addr_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_DATA && $past(state_q) == PH_AGAP) |-> (int'(quiet_run_q) >= AGAP_CYC));

  assert_data_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == PH_DATA && $past(state_q) == PH_DGAP) ||
     (state_q == PH_ADDR && $past(state_q) == PH_IDLE)) |-> (int'(quiet_run_q) >= DGAP_CYC));

  assert_gap_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == PH_AGAP || state_q == PH_DGAP) && $past(state_q) == state_q)
      |-> $stable({astb, dstb, rden, wren}));

  assert_load_on_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> expired);

  assert_no_busy_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_AGAP || state_q == PH_DATA || state_q == PH_DGAP) |=> (state_q != PH_ADDR));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/ixb_datapath.sv
module ixb_datapath
  import ixb_pkg::*;
#(
  parameter int REQ_IDX_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 capture,
  input  logic                 req_write,
  input  logic [REQ_IDX_W-1:0] req_index,
  input  logic [REG_W-1:0]     req_wdata,
  input  phase_t               phase,
  input  logic                 word_sel,
  input  logic                 sample,
  input  logic [WORD_W-1:0]    bus_in,
  output logic [WORD_W-1:0]    drive_word,
  output logic [REG_W-1:0]     rdata
);

  logic [PORT_IDX_W-1:0] idx_q;
  logic [REG_W-1:0]      wdata_q;
  logic [REG_W-1:0]      rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      wdata_q <= '0;
    end else if (capture) begin
      idx_q   <= req_index[PORT_IDX_W-1:0] | (req_write ? WRITE_FLAG : '0);
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= '0;
    end else if (sample) begin
      if (word_sel) rdata_q[REG_W-1:WORD_W] <= bus_in;
      else          rdata_q[WORD_W-1:0]     <= bus_in;
    end
  end

  always_comb begin
    if (phase == PH_ADDR)  drive_word = {{(WORD_W-PORT_IDX_W){1'b0}}, idx_q};
    else if (word_sel)     drive_word = wdata_q[REG_W-1:WORD_W];
    else                   drive_word = wdata_q[WORD_W-1:0];
  end

  assign rdata = rdata_q;

  // R3: a fresh access starts from a cleared result.
  assert_rdata_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (rdata_q == '0));

endmodule

// File: rtl/ixbus_bridge.sv
module ixbus_bridge
  import ixb_pkg::*;
#(
  parameter int CLK_PERIOD_NS  = 10,
  parameter int ADDR_SETTLE_NS = 300,
  parameter int DATA_SETTLE_NS = 150,
  parameter int STROBE_CYC     = 2,
  parameter int REQ_IDX_W      = 16,
  parameter int WIDE_BELOW     = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [REQ_IDX_W-1:0] req_index,
  input  logic [31:0]          req_wdata,
  output logic [31:0]          rsp_rdata,
  output logic                 rsp_done,
  output logic                 bus_astb,
  output logic                 bus_dstb,
  output logic                 bus_rden,
  output logic                 bus_wren,
  inout  wire  [15:0]          bus_data
);

  localparam int AGAP_CYC = ns_to_cycles(ADDR_SETTLE_NS, CLK_PERIOD_NS);
  localparam int DGAP_CYC = ns_to_cycles(DATA_SETTLE_NS, CLK_PERIOD_NS);
  localparam int STB_CYC  = (STROBE_CYC < 1) ? 1 : STROBE_CYC;
  localparam int MAX_A    = (AGAP_CYC > DGAP_CYC) ? AGAP_CYC : DGAP_CYC;
  localparam int MAX_CYC  = (MAX_A > STB_CYC) ? MAX_A : STB_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  logic               load, expired, word_sel, capture, sample, done;
  logic [CNT_W-1:0]   load_val;
  phase_t             phase;
  logic [WORD_W-1:0]  drive_word;

  ixb_gap_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  ixb_ctrl #(
    .STB_CYC    (STB_CYC),
    .AGAP_CYC   (AGAP_CYC),
    .DGAP_CYC   (DGAP_CYC),
    .CNT_W      (CNT_W),
    .WIDE_BELOW (WIDE_BELOW)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_port_idx (req_index[PORT_IDX_W-1:0]),
    .expired      (expired),
    .load         (load),
    .load_val     (load_val),
    .phase        (phase),
    .word_sel     (word_sel),
    .capture      (capture),
    .sample       (sample),
    .done         (done),
    .astb         (bus_astb),
    .dstb         (bus_dstb),
    .rden         (bus_rden),
    .wren         (bus_wren)
  );

  ixb_datapath #(.REQ_IDX_W(REQ_IDX_W)) u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (capture),
    .req_write  (req_write),
    .req_index  (req_index),
    .req_wdata  (req_wdata),
    .phase      (phase),
    .word_sel   (word_sel),
    .sample     (sample),
    .bus_in     (bus_data),
    .drive_word (drive_word),
    .rdata      (rsp_rdata)
  );

  assign bus_data  = bus_wren ? drive_word : 16'hzzzz;
  assign req_ready = (phase == PH_IDLE);
  assign rsp_done  = done;

  assert_ready_low_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !req_ready);

  assert_rd_wr_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rden |-> !bus_wren);

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({bus_astb, bus_dstb}) <= 1);

endmodule

// File: tb/tb_ixbus_bridge.sv
`timescale 1ns/1ps
module tb_ixbus_bridge;

  localparam int AGAP = 30;
  localparam int DGAP = 15;
  localparam int NV   = 12;

  // {write, index[15:0], wdata[31:0], expected[31:0], words[1:0]}
  localparam logic [82:0] VEC [NV] = '{
    {1'b1, 16'h0005, 32'hA5A5_1234, 32'h0000_0000, 2'd2},
    {1'b0, 16'h0005, 32'h0,         32'hA5A5_1234, 2'd2},
    {1'b1, 16'h0028, 32'hDEAD_BEEF, 32'h0000_0000, 2'd1},
    {1'b0, 16'h0028, 32'h0,         32'h0000_BEEF, 2'd1},
    {1'b0, 16'h001F, 32'h0,         32'hC01F_501F, 2'd2},
    {1'b1, 16'h0020, 32'h1234_5678, 32'h0000_0000, 2'd1},
    {1'b0, 16'h0020, 32'h0,         32'h0000_5678, 2'd1},
    {1'b0, 16'h0105, 32'h0,         32'hA5A5_1234, 2'd2},
    {1'b1, 16'h001F, 32'h0000_FFFF, 32'h0000_0000, 2'd2},
    {1'b0, 16'h001F, 32'h0,         32'h0000_FFFF, 2'd2},
    {1'b0, 16'h0030, 32'h0,         32'h0000_5030, 2'd1},
    {1'b0, 16'h0000, 32'h0,         32'hC000_5000, 2'd2}
  };

  logic        clk, rst_n;
  logic        req_valid, req_write;
  logic [15:0] req_index;
  logic [31:0] req_wdata;
  logic        req_ready, rsp_done;
  logic [31:0] rsp_rdata;
  logic        bus_astb, bus_dstb, bus_rden, bus_wren;
  wire  [15:0] bus_data;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  ixbus_bridge dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_index(req_index), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
    .bus_astb(bus_astb), .bus_dstb(bus_dstb), .bus_rden(bus_rden),
    .bus_wren(bus_wren), .bus_data(bus_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Peripheral register model
  logic [31:0] mem [128];
  logic [6:0]  mdl_idx;
  logic [7:0]  mon_addr;
  int          mon_words;
  logic [15:0] wr_word;
  logic        ds_was_wr;
  logic        as_p, ds_p, last_data;
  int          quiet;
  int addr_cnt = 0, agap_viol = 0, dgap_viol = 0, bus_viol = 0, addr_wr_viol = 0;
  logic [15:0] mdl_word;

  assign mdl_word = (mon_words == 0) ? mem[mdl_idx][15:0] : mem[mdl_idx][31:16];
  assign bus_data = bus_rden ? mdl_word : 16'hzzzz;

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = {16'hC000 + 16'(i), 16'h5000 + 16'(i)};
    mdl_idx = '0; mon_addr = '0; mon_words = 0; wr_word = '0; ds_was_wr = 0;
    as_p = 0; ds_p = 0; last_data = 0; quiet = 0;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      last_data = 0;
      as_p = 0;
      ds_p = 0;
      quiet = 0;
    end else begin
      if (bus_astb && !as_p) begin
        if (last_data && quiet < DGAP) dgap_viol++;
        addr_cnt++;
        mon_addr  = bus_data[7:0];
        mdl_idx   = bus_data[6:0];
        mon_words = 0;
        last_data = 0;
      end
      if (bus_astb && !bus_wren) addr_wr_viol++;
      if (bus_dstb && !ds_p) begin
        if (!last_data) begin
          if (quiet < AGAP) agap_viol++;
        end else if (quiet < DGAP) dgap_viol++;
      end
      if (bus_dstb) begin
        ds_was_wr = bus_wren;
        if (bus_wren) wr_word = bus_data;
      end
      if (!bus_dstb && ds_p) begin
        if (ds_was_wr) begin
          if (mon_words == 0) mem[mdl_idx][15:0]  = wr_word;
          else                mem[mdl_idx][31:16] = wr_word;
        end
        mon_words++;
        last_data = 1;
      end
      if (!bus_wren && !bus_rden && bus_data !== 16'hzzzz) bus_viol++;
      if (bus_rden && (^bus_data === 1'bx)) bus_viol++;
      if (bus_astb || bus_dstb) quiet = 0; else quiet++;
      as_p = bus_astb;
      ds_p = bus_dstb;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_ready();
    bit ok = 0;
    for (int k = 0; k < 2000; k++) begin
      if (req_ready) begin ok = 1; break; end
      @(negedge clk);
    end
    if (!ok) chk("R8 watchdog ready", 32'd0, 32'd1);
  endtask

  task automatic run_txn(input logic wr, input logic [15:0] idx, input logic [31:0] wd,
                         input logic [31:0] exp, input int nw, input bit hold_busy);
    int a0, g0, d0, b0, w0;
    logic [31:0] got_data;
    logic rdy_at_done, done_after;
    bit got = 0;
    wait_ready();
    a0 = addr_cnt; g0 = agap_viol; d0 = dgap_viol; b0 = bus_viol; w0 = addr_wr_viol;
    req_valid = 1; req_write = wr; req_index = idx; req_wdata = wd;
    @(negedge clk);
    if (hold_busy) begin
      req_write = ~wr; req_wdata = 32'h0; req_index = idx ^ 16'h0011;
    end else begin
      req_valid = 0;
    end
    got_data = '0; rdy_at_done = 1'b1;
    for (int k = 0; k < 2000; k++) begin
      if (rsp_done) begin got = 1; break; end
      @(negedge clk);
    end
    if (!got) chk("R9 watchdog done", 32'd0, 32'd1);
    got_data = rsp_rdata;
    rdy_at_done = req_ready;
    req_valid = 0;
    @(negedge clk);
    done_after = rsp_done;
    wait_ready();
    @(negedge clk);
    if (!wr) chk((nw == 2) ? "R2 read data" : "R3 read data", got_data, exp);
    chk("R1 index byte", {24'h0, mon_addr}, {24'h0, idx[7:0] | (wr ? 8'h80 : 8'h00)});
    chk("R1 write enable in address phase", 32'(addr_wr_viol - w0), 32'd0);
    chk("R8 one address phase per request", 32'(addr_cnt - a0), 32'd1);
    chk((nw == 2) ? "R2 word count" : "R3 word count", 32'(mon_words), 32'(nw));
    chk("R4 R6 quiet after address", 32'(agap_viol - g0), 32'd0);
    chk("R5 R6 quiet after data", 32'(dgap_viol - d0), 32'd0);
    chk("R7 bus ownership", 32'(bus_viol - b0), 32'd0);
    chk("R8 ready low at done", {31'h0, rdy_at_done}, 32'd0);
    chk("R9 done single cycle", {31'h0, done_after}, 32'd0);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_index = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 strobes idle", {28'h0, bus_astb, bus_dstb, bus_rden, bus_wren}, 32'd0);
    chk("R10 done low", {31'h0, rsp_done}, 32'd0);
    chk("R10 ready high", {31'h0, req_ready}, 32'd1);
    chk("R10 bus released", (bus_data === 16'hzzzz) ? 32'd1 : 32'd0, 32'd1);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run_txn(VEC[v][82], VEC[v][81:66], VEC[v][65:34], VEC[v][33:2], int'(VEC[v][1:0]), 1'b0);
    end

    // R8: request held while busy is not taken; register 0x05 left intact
    run_txn(1'b0, 16'h0005, 32'h0, 32'hA5A5_1234, 2, 1'b1);
    run_txn(1'b0, 16'h0014, 32'h0, 32'hC014_5014, 2, 1'b0);
    run_txn(1'b0, 16'h0005, 32'h0, 32'hA5A5_1234, 2, 1'b0);

    // R10: reset in the middle of a data strobe
    wait_ready();
    req_valid = 1; req_write = 1; req_index = 16'h0006; req_wdata = 32'h1111_2222;
    @(negedge clk);
    req_valid = 0;
    for (int k = 0; k < 200 && !bus_dstb; k++) @(negedge clk);
    chk("R10 reached data phase", {31'h0, bus_dstb}, 32'd1);
    rst_n = 0;
    #1;
    chk("R10 strobes cleared mid-access", {28'h0, bus_astb, bus_dstb, bus_rden, bus_wren}, 32'd0);
    chk("R10 bus released mid-access", (bus_data === 16'hzzzz) ? 32'd1 : 32'd0, 32'd1);
    chk("R10 ready after reset", {31'h0, req_ready}, 32'd1);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    run_txn(1'b0, 16'h0000, 32'h0, 32'hC000_5000, 2, 1'b0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule